// File: doc/BRIEF.md
# Host Controller Control Register

This block holds the 32-bit control word of a serial-bus host controller, placed at byte offset 4 of its register window, together with the small amount of sequencing needed to carry out the requests written into it. Software reaches it through a plain read/write strobe interface. The transfer engine reports its progress through single-cycle strobes: command started, command done with its end-of-queue flag, transfer error and byte boundary reached. It also reports a level that stays high while an in-band interrupt is being received.

A disable request does not act at once. The enable bit reads back 1, and the bus stays usable, until no interrupt is being received and the command queue has drained to a command flagged as last. A transfer error puts the controller into a halt that only a software resume clears. The resume bit then clears itself as soon as the next command starts. An abort request asks for a STOP condition, which is issued at the next byte boundary, and it blocks bus operation until software clears it. Three static configuration levels are also held here. A 2-bit state code is exported for a separate status register.

Top module: `hc_ctrl_reg`

## Requirements
- R1: After synchronous reset, a read at offset 4 returns 0x00000001. The state code is 0, and `bus_run`, `stop_req`, `halted`, `hj_ack` and `i2c_present` are 0, while `bcast_incl` is 1.
- R2: A write at offset 4 with bit 31 = 1 sets the enable (`bus_en` and read bit 31) at that clock edge. A write with bit 31 = 0 while idle and with no interrupt being received clears it at that edge.
- R3: While `ibi_active` is 1, a requested disable is held: bit 31 reads 1 and `bus_en` stays 1. They drop at the first edge at which `ibi_active` is seen low and no command is outstanding.
- R4: A command is outstanding from a `cmd_start` strobe until a `cmd_done` strobe with `cmd_toc` = 1, or until a transfer error. A disable waits for this. `cmd_done` with `cmd_toc` = 0 does not release it.
- R5: An `xfer_err` strobe sets `halted` at that edge. `halted` stays set, with `bus_run` low, until a write at offset 4 with bit 30 = 1. Such a write clears `halted` unless an error arrives in the same cycle.
- R6: Bit 30 (resume) reads back as written. Hardware clears it at the edge of a `cmd_start` strobe that arrives while not halted, and this clear takes priority over a software write in the same cycle.
- R7: While bit 29 (abort) is 1, `bus_run` is 0. The first `byte_done` strobe seen with abort set makes `stop_req` high for exactly the next cycle. No further STOP is issued until abort has been cleared and set again. Abort stays set until software writes it to 0.
- R8: Bit 8 (`hj_ack`), bit 7 (`i2c_present`) and bit 0 (`bcast_incl`) are plain read/write bits driven to the matching output levels.
- R9: Bits 28:9 and 6:1 always read 0, whatever was written to them.
- R10: The state code is 2 (halt) when halted. Otherwise it is 3 (disabling) while a disable is pending, 1 (active) while a command is outstanding, and 0 (idle) in any other case.
- R11: Reads at any other offset return 0, and writes at any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| rd_en | input | 1 | Software read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when not selected |
| ibi_active | input | 1 | In-band interrupt reception in progress |
| cmd_start | input | 1 | Engine started a command |
| cmd_done | input | 1 | Engine completed a command |
| cmd_toc | input | 1 | Completed command was flagged last in queue |
| xfer_err | input | 1 | Transfer error strobe |
| byte_done | input | 1 | Byte boundary reached on the bus |
| bus_en | output | 1 | Effective enable; 0 forbids clocking for incoming interrupts |
| bus_run | output | 1 | Bus operation allowed (enabled, not halted, no abort) |
| halted | output | 1 | Controller in error halt |
| stop_req | output | 1 | One-cycle STOP request |
| state_code | output | 2 | 0 idle, 1 active, 2 halt, 3 disabling |
| hj_ack | output | 1 | Hot-join acknowledge control level |
| i2c_present | output | 1 | Legacy I2C target on the bus |
| bcast_incl | output | 1 | Send broadcast address before private transfers |

## Verification
A stuck or wrongly updated outstanding-command flag shows up on `state_code` one cycle after the command strobe. It also shows up as a disable that finishes too early or never finishes, visible on `bus_en` and read bit 31 at the completion edge. A lost halt or resume bit shows up on `halted`, `bus_run` and read bit 30 in the cycle after the error, the resume write or the start strobe. An abort latch fault shows up as a missing or repeated `stop_req` pulse in the cycle after a byte boundary. The bench runs a model built from the requirements alongside the design and compares every output and a full register read each cycle, so any such divergence is reported within one cycle.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

    localparam int DATA_W  = 32;
    localparam int BIT_EN  = 31;
    localparam int BIT_RES = 30;
    localparam int BIT_ABT = 29;
    localparam int BIT_HJ  = 8;
    localparam int BIT_I2C = 7;
    localparam int BIT_BC  = 0;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACTIVE    = 2'd1,
        ST_HALT      = 2'd2,
        ST_DISABLING = 2'd3
    } hc_state_e;

    typedef struct packed {
        logic en;
        logic resume;
        logic abort;
        logic hj;
        logic i2c;
        logic bcast;
    } ctl_fields_t;

    function automatic ctl_fields_t fields_from_word(input logic [DATA_W-1:0] w);
        ctl_fields_t f;
        f.en     = w[BIT_EN];
        f.resume = w[BIT_RES];
        f.abort  = w[BIT_ABT];
        f.hj     = w[BIT_HJ];
        f.i2c    = w[BIT_I2C];
        f.bcast  = w[BIT_BC];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] word_from_fields(input ctl_fields_t f);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[BIT_EN]  = f.en;
        w[BIT_RES] = f.resume;
        w[BIT_ABT] = f.abort;
        w[BIT_HJ]  = f.hj;
        w[BIT_I2C] = f.i2c;
        w[BIT_BC]  = f.bcast;
        return w;
    endfunction

    function automatic hc_state_e state_select(input logic halt, input logic pend,
                                               input logic busy);
        if (halt)      return ST_HALT;
        else if (pend) return ST_DISABLING;
        else if (busy) return ST_ACTIVE;
        else           return ST_IDLE;
    endfunction

endpackage

// File: rtl/hcc_cfg_bits.sv
module hcc_cfg_bits
    import hcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  ctl_fields_t wf,
    output logic        abort,
    output logic        hj,
    output logic        i2c,
    output logic        bcast
);

    always_ff @(posedge clk) begin
        if (rst) begin
            abort <= 1'b0;
            hj    <= 1'b0;
            i2c   <= 1'b0;
            bcast <= 1'b1;
        end else if (wr_hit) begin
            abort <= wf.abort;
            hj    <= wf.hj;
            i2c   <= wf.i2c;
            bcast <= wf.bcast;
        end
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(hj) && $stable(i2c) && $stable(bcast) && $stable(abort));

endmodule

// File: rtl/hcc_enable_ctl.sv
module hcc_enable_ctl
    import hcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_en_bit,
    input  logic ibi_active,
    input  logic cmd_start,
    input  logic cmd_done,
    input  logic cmd_toc,
    input  logic xfer_err,
    output logic en,
    output logic pend,
    output logic busy
);

    logic en_n, pend_n, busy_n, quiet;

    always_comb begin
        busy_n = busy;
        if (cmd_done && cmd_toc) busy_n = 1'b0;
        if (cmd_start)           busy_n = 1'b1;
        if (xfer_err)            busy_n = 1'b0;

        quiet  = !ibi_active && !busy_n;
        en_n   = en;
        pend_n = pend;
        if (wr_hit) begin
            if (wr_en_bit) begin
                en_n   = 1'b1;
                pend_n = 1'b0;
            end else if (en) begin
                pend_n = 1'b1;
            end
        end
        if (pend_n && quiet) begin
            en_n   = 1'b0;
            pend_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            pend <= 1'b0;
            busy <= 1'b0;
        end else begin
            en   <= en_n;
            pend <= pend_n;
            busy <= busy_n;
        end
    end

    // R3
    dis_after_ibi_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> $past(!ibi_active));

    // R4
    dis_waits_toc_chk: assert property (@(posedge clk) disable iff (rst)
        (en && busy && !cmd_done && !xfer_err) |=> en);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_en_bit) |=> (en && !pend));

endmodule

// File: rtl/hcc_halt_ctl.sv
module hcc_halt_ctl
    import hcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_resume,
    input  logic xfer_err,
    input  logic cmd_start,
    input  logic abort,
    input  logic byte_done,
    output logic halted,
    output logic resume,
    output logic stop_req
);

    logic halted_n, resume_n, sent, sent_n, stop_n;

    always_comb begin
        halted_n = halted;
        if (wr_hit && wr_resume) halted_n = 1'b0;
        if (xfer_err)            halted_n = 1'b1;

        resume_n = resume;
        if (wr_hit)                resume_n = wr_resume;
        if (cmd_start && !halted)  resume_n = 1'b0;

        sent_n = sent;
        stop_n = 1'b0;
        if (!abort) begin
            sent_n = 1'b0;
        end else if (byte_done && !sent) begin
            sent_n = 1'b1;
            stop_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted   <= 1'b0;
            resume   <= 1'b0;
            sent     <= 1'b0;
            stop_req <= 1'b0;
        end else begin
            halted   <= halted_n;
            resume   <= resume_n;
            sent     <= sent_n;
            stop_req <= stop_n;
        end
    end

    // R5
    halt_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_err |=> halted);

    // R6
    resume_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !halted) |=> !resume);

    // R7
    stop_at_byte_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> $past(abort && byte_done));

    // R7
    stop_single_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !stop_req);

endmodule

// File: rtl/hc_ctrl_reg.sv
module hc_ctrl_reg
    import hcc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ibi_active,
    input  logic              cmd_start,
    input  logic              cmd_done,
    input  logic              cmd_toc,
    input  logic              xfer_err,
    input  logic              byte_done,
    output logic              bus_en,
    output logic              bus_run,
    output logic              halted,
    output logic              stop_req,
    output logic [1:0]        state_code,
    output logic              hj_ack,
    output logic              i2c_present,
    output logic              bcast_incl
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    logic        wr_hit, rd_hit;
    ctl_fields_t wf, rf;
    logic        abort_q, pend_q, busy_q, resume_q;
    hc_state_e   st;

    assign wr_hit = wr_en && (addr == OFFS);
    assign rd_hit = rd_en && (addr == OFFS);
    assign wf     = fields_from_word(wdata);

    hcc_cfg_bits u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(wr_hit),
        .wf    (wf),
        .abort (abort_q),
        .hj    (hj_ack),
        .i2c   (i2c_present),
        .bcast (bcast_incl)
    );

    hcc_enable_ctl u_en (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_hit),
        .wr_en_bit (wf.en),
        .ibi_active(ibi_active),
        .cmd_start (cmd_start),
        .cmd_done  (cmd_done),
        .cmd_toc   (cmd_toc),
        .xfer_err  (xfer_err),
        .en        (bus_en),
        .pend      (pend_q),
        .busy      (busy_q)
    );

    hcc_halt_ctl u_halt (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .wr_resume(wf.resume),
        .xfer_err (xfer_err),
        .cmd_start(cmd_start),
        .abort    (abort_q),
        .byte_done(byte_done),
        .halted   (halted),
        .resume   (resume_q),
        .stop_req (stop_req)
    );

    always_comb begin
        rf.en     = bus_en;
        rf.resume = resume_q;
        rf.abort  = abort_q;
        rf.hj     = hj_ack;
        rf.i2c    = i2c_present;
        rf.bcast  = bcast_incl;
    end

    assign rdata      = rd_hit ? word_from_fields(rf) : '0;
    assign st         = state_select(halted, pend_q, busy_q);
    assign state_code = st;
    assign bus_run    = bus_en && !halted && !abort_q;

    // R10
    halt_code_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_err |=> (state_code == 2'd2));

    // R11
    miss_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != OFFS) |-> (rdata == 32'd0));

endmodule

// File: tb/hc_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module hc_ctrl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata;
    logic        ibi_active, cmd_start, cmd_done, cmd_toc, xfer_err, byte_done;
    logic        bus_en, bus_run, halted, stop_req, hj_ack, i2c_present, bcast_incl;
    logic [1:0]  state_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic m_en, m_pend, m_busy, m_halt, m_res, m_abort, m_sent, m_stop;
    logic m_hj, m_i2c, m_bc;

    always #2.5 clk = ~clk;

    hc_ctrl_reg dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ibi_active(ibi_active),
        .cmd_start(cmd_start), .cmd_done(cmd_done), .cmd_toc(cmd_toc),
        .xfer_err(xfer_err), .byte_done(byte_done), .bus_en(bus_en),
        .bus_run(bus_run), .halted(halted), .stop_req(stop_req),
        .state_code(state_code), .hj_ack(hj_ack), .i2c_present(i2c_present),
        .bcast_incl(bcast_incl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[31] = m_en; w[30] = m_res; w[29] = m_abort;
        w[8] = m_hj; w[7] = m_i2c; w[0] = m_bc;
        return w;
    endfunction

    function automatic logic [1:0] exp_state();
        if (m_halt) return 2'd2;
        if (m_pend) return 2'd3;
        if (m_busy) return 2'd1;
        return 2'd0;
    endfunction

    task automatic m_reset();
        m_en = 0; m_pend = 0; m_busy = 0; m_halt = 0; m_res = 0;
        m_abort = 0; m_sent = 0; m_stop = 0; m_hj = 0; m_i2c = 0; m_bc = 1;
    endtask

    task automatic m_step();
        logic hit = wr_en && addr == 8'd4;
        logic nb = m_busy, ne = m_en, np = m_pend, nh = m_halt, nr = m_res;
        logic ns = m_sent, nst = 1'b0;
        if (cmd_done && cmd_toc) nb = 0;
        if (cmd_start) nb = 1;
        if (xfer_err) nb = 0;
        if (hit) begin
            if (wdata[31]) begin ne = 1; np = 0; end
            else if (m_en) np = 1;
        end
        if (np && !ibi_active && !nb) begin ne = 0; np = 0; end
        if (hit && wdata[30]) nh = 0;
        if (xfer_err) nh = 1;
        if (hit) nr = wdata[30];
        if (cmd_start && !m_halt) nr = 0;
        if (!m_abort) ns = 0;
        else if (byte_done && !m_sent) begin ns = 1; nst = 1; end
        if (hit) begin
            m_abort = wdata[29]; m_hj = wdata[8]; m_i2c = wdata[7]; m_bc = wdata[0];
        end
        m_busy = nb; m_en = ne; m_pend = np; m_halt = nh; m_res = nr;
        m_sent = ns; m_stop = nst;
    endtask

    task automatic tick();
        m_step();
        @(posedge clk);
        #1;
        wr_en = 0; cmd_start = 0; cmd_done = 0; cmd_toc = 0;
        xfer_err = 0; byte_done = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1; addr = 8'd4; wdata = d;
        tick();
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1; addr = a;
        #0.2;
        v = rdata;
        rd_en = 0; addr = 8'd4;
    endtask

    task automatic cmp_all(input string tag);
        logic [31:0] v;
        rd(8'd4, v);
        chk({tag, " read"}, v, exp_word());
        chk({tag, " state"}, {30'd0, state_code}, {30'd0, exp_state()});
        chk({tag, " outs"}, {25'd0, bus_en, bus_run, halted, stop_req, hj_ack, i2c_present, bcast_incl},
            {25'd0, m_en, m_en && !m_halt && !m_abort, m_halt, m_stop, m_hj, m_i2c, m_bc});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1; wr_en = 0; rd_en = 0; addr = 8'd4; wdata = 0;
        ibi_active = 0; cmd_start = 0; cmd_done = 0; cmd_toc = 0;
        xfer_err = 0; byte_done = 0;
        m_reset();
        repeat (3) @(posedge clk);
        #1; rst = 0;

        // R1 reset state
        rd(8'd4, v); chk("R1 reset read", v, 32'h0000_0001);
        chk("R1 reset state", {30'd0, state_code}, 32'd0);
        chk("R1 reset outs", {25'd0, bus_en, bus_run, halted, stop_req, hj_ack, i2c_present, bcast_incl}, 32'h1);

        // R8 config bits
        wr(32'h0000_0180);
        chk("R8 cfg outs", {29'd0, hj_ack, i2c_present, bcast_incl}, 32'h6);
        rd(8'd4, v); chk("R8 cfg read", v, 32'h0000_0180);

        // R9 reserved bits
        wr(32'h1FFF_FE7E);
        rd(8'd4, v); chk("R9 reserved read", v, 32'h0000_0000);

        // R2 enable / immediate disable
        wr(32'h8000_0001);
        chk("R2 enable", {30'd0, bus_en, bus_run}, 32'h3);
        wr(32'h0000_0001);
        chk("R2 idle disable", {31'd0, bus_en}, 32'd0);

        // R4 disable waits for TOC completion
        wr(32'h8000_0001);
        cmd_start = 1; tick();
        chk("R10 active code", {30'd0, state_code}, 32'd1);
        wr(32'h0000_0001);
        rd(8'd4, v); chk("R4 pending readback", v[31], 1'b1);
        chk("R10 disabling code", {30'd0, state_code}, 32'd3);
        cmd_done = 1; cmd_toc = 0; tick();
        chk("R4 toc0 holds", {31'd0, bus_en}, 32'd1);
        cmd_done = 1; cmd_toc = 1; tick();
        chk("R4 toc1 releases", {31'd0, bus_en}, 32'd0);
        chk("R10 idle code", {30'd0, state_code}, 32'd0);

        // R3 disable waits for IBI end
        wr(32'h8000_0001);
        ibi_active = 1;
        wr(32'h0000_0001);
        tick(); tick();
        rd(8'd4, v); chk("R3 held during ibi", v[31], 1'b1);
        ibi_active = 0; tick();
        chk("R3 released after ibi", {31'd0, bus_en}, 32'd0);

        // R5 halt and resume
        wr(32'h8000_0001);
        xfer_err = 1; tick();
        chk("R5 halted", {29'd0, halted, bus_run, state_code == 2'd2}, 32'h5);
        tick(); tick();
        chk("R5 stays halted", {31'd0, halted}, 32'd1);
        wr(32'hC000_0001);
        rd(8'd4, v); chk("R5 resume clears halt", {halted, v[30]}, 2'b01);
        // R6 self-clear
        cmd_start = 1; tick();
        rd(8'd4, v); chk("R6 resume self-clear", v[30], 1'b0);
        cmd_done = 1; cmd_toc = 1; tick();
        // R6 hardware clear wins over write
        wr_en = 1; addr = 8'd4; wdata = 32'hC000_0001; cmd_start = 1; tick();
        rd(8'd4, v); chk("R6 hw priority", v[30], 1'b0);
        cmd_done = 1; cmd_toc = 1; tick();

        // R7 abort
        wr(32'hA000_0001);
        chk("R7 abort blocks run", {31'd0, bus_run}, 32'd0);
        tick();
        chk("R7 no stop before byte", {31'd0, stop_req}, 32'd0);
        byte_done = 1; tick();
        chk("R7 stop pulse", {31'd0, stop_req}, 32'd1);
        tick();
        chk("R7 stop one cycle", {31'd0, stop_req}, 32'd0);
        byte_done = 1; tick(); tick();
        chk("R7 no second stop", {31'd0, stop_req}, 32'd0);
        rd(8'd4, v); chk("R7 abort sticky", v[29], 1'b1);
        wr(32'h8000_0001);
        chk("R7 cleared abort runs", {31'd0, bus_run}, 32'd1);

        // R11 other offsets
        rd(8'd8, v); chk("R11 miss read", v, 32'd0);
        wr_en = 1; addr = 8'd8; wdata = 32'h0000_0180; tick();
        rd(8'd4, v); chk("R11 miss write ignored", v, 32'h8000_0001);

        // Random phase against the model, all requirements
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom();
            if (r[3:0] == 4'd0) begin
                wr_en = 1;
                addr  = (r[4]) ? 8'd4 : 8'd12;
                wdata = {r[31:29] | {r[28], 2'b00}, 20'h0, r[8:7], 6'h0, r[5]};
            end
            ibi_active = (r[11:9] == 3'd0) ? ~ibi_active : ibi_active;
            cmd_start  = (r[14:12] == 3'd1);
            cmd_done   = (r[17:15] == 3'd2);
            cmd_toc    = r[18];
            xfer_err   = (r[24:20] == 5'd3);
            byte_done  = r[25] & r[26];
            tick();
            cmp_all("R1-model R2 R3 R4 R5 R6 R7 R8 R10");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule